// File: doc/BRIEF.md
# Exception and Privilege Mode Controller

This block is the exception and privilege unit of a 32-bit processor. It holds a one-bit execution mode (1 = kernel, 0 = user), the saved exception PC, a cause code, the captured faulting address and a six-bit interrupt mask. Each cycle the pipeline presents the PC of the current instruction, an optional data access, decoded instruction-class flags, bus error flags, six interrupt lines, a non-maskable interrupt line and a return-from-exception request.

When any cause is present, the block raises `exc_taken_o` in the same cycle. It steers the fetch to the fixed handler vector 0x80000180 and records the cause. On the next clock edge it switches to kernel mode. A return request steers the fetch back to the saved PC and restores the mode that was active when the exception was taken. A status write, which is accepted only in kernel mode, sets the mode and the interrupt mask.

Top module: `exc_mode_ctrl`

## Requirements
- R1: After reset the mode is kernel (`kernel_o`=1), the mask, saved PC, cause and faulting address all read 0, and no redirect is requested.
- R2: When any cause is taken, `exc_taken_o` is high in that same cycle and `redirect_pc_o` is 0x80000180. From the next cycle the mode is kernel.
- R3: Address bit 31 divides the space: 0x00000000–0x7FFFFFFF is user space and 0x80000000–0xFFFFFFFF is kernel space. In user mode, the following raise an address error: a valid data access to kernel space (cause 4 for a load, 5 for a store), and an instruction PC in kernel space (cause 4). In kernel mode neither raises an error.
- R4: A reserved instruction raises cause 10. A privileged instruction raises cause 10 in user mode and has no effect in kernel mode.
- R5: The cause codes are: syscall 8, break 9, trap 13, integer overflow 12, floating-point error 15, bus error 6 on a fetch and 7 on a data access.
- R6: For bus errors, address errors and reserved instructions, the saved PC is the instruction PC. For all other causes it is the PC plus 4.
- R7: The faulting-address output captures the offending address (the data address, or the PC for a fetch) on an address error. It is unchanged by every other cause.
- R8: When several causes are present, one is taken in this order: NMI, bus error, fetch address error, data address error, reserved, syscall, break, trap, overflow, floating-point error, interrupt.
- R9: A rising edge on `nmi_i` causes exactly one exception, with cause 0 and saved PC equal to the PC plus 4. Holding the line high causes nothing further.
- R10: Interrupt line i is taken only when `irq_i[i]`, mask bit i and `boundary_i` are all high. It records cause 0 and saves the PC plus 4. If a synchronous cause is present in the same cycle, that cause is recorded instead.
- R11: A return request with no cause present in that cycle sets `redirect_o`, makes `redirect_pc_o` the saved PC, and restores the saved mode on the next edge. If a cause is present, the exception wins.
- R12: A status write sets the mode and the mask on the next edge, but only in kernel mode and only when no cause is taken in that cycle. In user mode the write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pc_i | input | 32 | PC of current instruction |
| boundary_i | input | 1 | Instruction boundary; interrupts sampled only here |
| mem_valid_i | input | 1 | Data access present |
| mem_store_i | input | 1 | Data access is a store |
| mem_addr_i | input | 32 | Data access address |
| priv_i | input | 1 | Instruction is privileged |
| resv_i | input | 1 | Instruction is reserved/undefined |
| syscall_i | input | 1 | System call instruction |
| break_i | input | 1 | Break instruction |
| trap_i | input | 1 | Trap instruction with true condition |
| ovf_i | input | 1 | Integer overflow |
| fpu_err_i | input | 1 | Floating-point unit error |
| bus_err_i | input | 1 | Bus error |
| bus_fetch_i | input | 1 | Bus error came from a fetch |
| irq_i | input | 6 | Hardware interrupt lines |
| nmi_i | input | 1 | Non-maskable interrupt line |
| eret_i | input | 1 | Return-from-exception request |
| st_we_i | input | 1 | Status write |
| st_mode_i | input | 1 | Mode value to write |
| st_mask_i | input | 6 | Interrupt mask to write |
| exc_taken_o | output | 1 | Exception taken this cycle |
| redirect_o | output | 1 | Fetch redirect request |
| redirect_pc_o | output | 32 | Redirect target |
| kernel_o | output | 1 | Current mode (1 = kernel) |
| epc_o | output | 32 | Saved exception PC |
| cause_o | output | 5 | Recorded cause code |
| badva_o | output | 32 | Captured faulting address |
| mask_o | output | 6 | Interrupt mask |

## Verification
The instruction-class flags are first applied one at a time in user mode. This separates the cause codes and shows which classes save the current PC and which save the next PC. An address sweep steps through every eighth of the address space, including 0x7FFFFFFF and 0x80000000, for both loads and stores. This locates the user/kernel boundary and tells cause 4 from cause 5. All 63 combinations of six synchronous causes are then applied, with an unmasked interrupt pending in each, to pin down the priority order. A grid of interrupt line against mask against boundary flag, together with held versus toggled NMI levels, separates level-sampled interrupts from the edge-detected NMI.

// File: rtl/exc_mode_ctrl.sv
module exc_mode_ctrl #(
  parameter logic [31:0] VECTOR = 32'h8000_0180,
  parameter int NIRQ = 6,
  parameter int CW = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [31:0]     pc_i,
  input  logic            boundary_i,
  input  logic            mem_valid_i,
  input  logic            mem_store_i,
  input  logic [31:0]     mem_addr_i,
  input  logic            priv_i,
  input  logic            resv_i,
  input  logic            syscall_i,
  input  logic            break_i,
  input  logic            trap_i,
  input  logic            ovf_i,
  input  logic            fpu_err_i,
  input  logic            bus_err_i,
  input  logic            bus_fetch_i,
  input  logic [NIRQ-1:0] irq_i,
  input  logic            nmi_i,
  input  logic            eret_i,
  input  logic            st_we_i,
  input  logic            st_mode_i,
  input  logic [NIRQ-1:0] st_mask_i,
  output logic            exc_taken_o,
  output logic            redirect_o,
  output logic [31:0]     redirect_pc_o,
  output logic            kernel_o,
  output logic [31:0]     epc_o,
  output logic [CW-1:0]   cause_o,
  output logic [31:0]     badva_o,
  output logic [NIRQ-1:0] mask_o
);

  localparam logic [CW-1:0] C_INT  = CW'(0);
  localparam logic [CW-1:0] C_ADEL = CW'(4);
  localparam logic [CW-1:0] C_ADES = CW'(5);
  localparam logic [CW-1:0] C_IBE  = CW'(6);
  localparam logic [CW-1:0] C_DBE  = CW'(7);
  localparam logic [CW-1:0] C_SYS  = CW'(8);
  localparam logic [CW-1:0] C_BRK  = CW'(9);
  localparam logic [CW-1:0] C_RI   = CW'(10);
  localparam logic [CW-1:0] C_OV   = CW'(12);
  localparam logic [CW-1:0] C_TRAP = CW'(13);
  localparam logic [CW-1:0] C_FPE  = CW'(15);

  logic            mode_q, prev_q, nmi_q;
  logic [31:0]     epc_q, bad_q;
  logic [CW-1:0]   cause_q;
  logic [NIRQ-1:0] mask_q;

  logic            user, nmi_edge, fetch_ae, data_ae, ri, irq_take, sync, take, eret_ok;
  logic [CW-1:0]   code;
  logic            keep_pc, load_bad;
  logic [31:0]     bad_val;

  assign user     = ~mode_q;
  assign nmi_edge = nmi_i & ~nmi_q;
  assign fetch_ae = user & pc_i[31];
  assign data_ae  = user & mem_valid_i & mem_addr_i[31];
  assign ri       = resv_i | (priv_i & user);
  assign irq_take = boundary_i & (|(irq_i & mask_q));
  assign sync     = nmi_edge | bus_err_i | fetch_ae | data_ae | ri |
                    syscall_i | break_i | trap_i | ovf_i | fpu_err_i;
  assign take     = sync | irq_take;
  assign eret_ok  = eret_i & ~take;

  always_comb begin
    code     = C_INT;
    keep_pc  = 1'b0;
    load_bad = 1'b0;
    bad_val  = mem_addr_i;
    if (nmi_edge) begin
      code = C_INT;
    end else if (bus_err_i) begin
      code    = bus_fetch_i ? C_IBE : C_DBE;
      keep_pc = 1'b1;
    end else if (fetch_ae) begin
      code     = C_ADEL;
      keep_pc  = 1'b1;
      load_bad = 1'b1;
      bad_val  = pc_i;
    end else if (data_ae) begin
      code     = mem_store_i ? C_ADES : C_ADEL;
      keep_pc  = 1'b1;
      load_bad = 1'b1;
    end else if (ri) begin
      code    = C_RI;
      keep_pc = 1'b1;
    end else if (syscall_i) code = C_SYS;
    else if (break_i)       code = C_BRK;
    else if (trap_i)        code = C_TRAP;
    else if (ovf_i)         code = C_OV;
    else if (fpu_err_i)     code = C_FPE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= 1'b1;
      prev_q  <= 1'b1;
      nmi_q   <= 1'b0;
      epc_q   <= '0;
      bad_q   <= '0;
      cause_q <= '0;
      mask_q  <= '0;
    end else begin
      nmi_q <= nmi_i;
      if (take) begin
        mode_q  <= 1'b1;
        prev_q  <= mode_q;
        epc_q   <= keep_pc ? pc_i : pc_i + 32'd4;
        cause_q <= code;
        if (load_bad) bad_q <= bad_val;
      end else if (eret_ok) begin
        mode_q <= prev_q;
      end else if (st_we_i && mode_q) begin
        mode_q <= st_mode_i;
        mask_q <= st_mask_i;
      end
    end
  end

  assign exc_taken_o   = take;
  assign redirect_o    = take | eret_ok;
  assign redirect_pc_o = take ? VECTOR : (eret_ok ? epc_q : 32'd0);
  assign kernel_o      = mode_q;
  assign epc_o         = epc_q;
  assign cause_o       = cause_q;
  assign badva_o       = bad_q;
  assign mask_o        = mask_q;

endmodule

module exc_mode_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] pc_i,
  input logic        mem_valid_i,
  input logic [31:0] mem_addr_i,
  input logic        nmi_i,
  input logic        eret_i,
  input logic        exc_taken_o,
  input logic        redirect_o,
  input logic [31:0] redirect_pc_o,
  input logic        kernel_o,
  input logic [31:0] epc_o,
  input logic [31:0] badva_o
);

  a_r2_kernel_entry: assert property (@(posedge clk) disable iff (!rst_n)
    exc_taken_o |=> kernel_o);

  a_r6_epc_choice: assert property (@(posedge clk) disable iff (!rst_n)
    exc_taken_o |=> (epc_o == $past(pc_i) || epc_o == $past(pc_i) + 32'd4));

  a_r7_badva_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !exc_taken_o |=> $stable(badva_o));

  a_r9_nmi_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nmi_i) |-> exc_taken_o);

  a_r3_user_kspace: assert property (@(posedge clk) disable iff (!rst_n)
    (!kernel_o && mem_valid_i && mem_addr_i[31]) |-> exc_taken_o);

  a_r11_eret_target: assert property (@(posedge clk) disable iff (!rst_n)
    (eret_i && !exc_taken_o) |-> (redirect_o && redirect_pc_o == epc_o));

endmodule

bind exc_mode_ctrl exc_mode_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pc_i(pc_i), .mem_valid_i(mem_valid_i),
  .mem_addr_i(mem_addr_i), .nmi_i(nmi_i), .eret_i(eret_i),
  .exc_taken_o(exc_taken_o), .redirect_o(redirect_o),
  .redirect_pc_o(redirect_pc_o), .kernel_o(kernel_o), .epc_o(epc_o),
  .badva_o(badva_o)
);

// File: tb/sim_exc_mode_ctrl.sv
`timescale 1ns/1ps
module sim_exc_mode_ctrl;
  localparam logic [31:0] VEC = 32'h8000_0180;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [31:0] pc_i, mem_addr_i;
  logic boundary_i, mem_valid_i, mem_store_i, priv_i, resv_i, syscall_i, break_i;
  logic trap_i, ovf_i, fpu_err_i, bus_err_i, bus_fetch_i, nmi_i, eret_i, st_we_i, st_mode_i;
  logic [5:0] irq_i, st_mask_i;
  logic exc_taken_o, redirect_o, kernel_o;
  logic [31:0] redirect_pc_o, epc_o, badva_o;
  logic [4:0] cause_o;
  logic [5:0] mask_o;

  int checks = 0, errors = 0;
  logic        m_mode, m_prev;
  logic [31:0] m_epc, m_bad;
  logic [4:0]  m_cause;
  logic [5:0]  m_mask;

  always #2.5 clk = ~clk;

  exc_mode_ctrl u0 (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    boundary_i = 0; mem_valid_i = 0; mem_store_i = 0; mem_addr_i = 0;
    priv_i = 0; resv_i = 0; syscall_i = 0; break_i = 0; trap_i = 0; ovf_i = 0;
    fpu_err_i = 0; bus_err_i = 0; bus_fetch_i = 0; irq_i = 0; eret_i = 0;
    st_we_i = 0; st_mode_i = 0; st_mask_i = 0;
  endtask

  task automatic state_chk(input string tag);
    chk(kernel_o === m_mode, {tag, " mode"}, 32'(kernel_o), 32'(m_mode));
    chk(epc_o === m_epc, {tag, " epc"}, epc_o, m_epc);
    chk(cause_o === m_cause, {tag, " cause"}, 32'(cause_o), 32'(m_cause));
    chk(badva_o === m_bad, {tag, " badva"}, badva_o, m_bad);
    chk(mask_o === m_mask, {tag, " mask"}, 32'(mask_o), 32'(m_mask));
  endtask

  task automatic expect_exc(input string tag, input bit take, input logic [4:0] code,
                            input bit cur, input bit bad_en, input logic [31:0] bad);
    #1;
    chk(exc_taken_o === take, {tag, " taken"}, 32'(exc_taken_o), 32'(take));
    if (take) begin
      chk(redirect_pc_o === VEC, {tag, " vector R2"}, redirect_pc_o, VEC);
      m_prev = m_mode; m_mode = 1'b1;
      m_epc = cur ? pc_i : pc_i + 32'd4;
      m_cause = code;
      if (bad_en) m_bad = bad;
    end
    @(negedge clk);
    state_chk(tag);
    idle();
  endtask

  task automatic go_user(input logic [5:0] msk);
    st_we_i = 1; st_mode_i = 0; st_mask_i = msk;
    @(negedge clk);
    if (m_mode) begin m_mode = 0; m_mask = msk; end
    idle();
    chk(kernel_o === m_mode && mask_o === m_mask, "R12 status write", {25'd0, kernel_o, mask_o}, {25'd0, m_mode, m_mask});
  endtask

  function automatic logic [4:0] prio_code(input logic [5:0] s);
    if (s[0]) return 5'd7;
    if (s[1]) return 5'd4;
    if (s[2]) return 5'd10;
    if (s[3]) return 5'd8;
    if (s[4]) return 5'd9;
    return 5'd12;
  endfunction

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(); pc_i = 0; nmi_i = 0;
    m_mode = 1; m_prev = 1; m_epc = 0; m_bad = 0; m_cause = 0; m_mask = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    state_chk("R1 reset");
    chk(redirect_o === 1'b0, "R1 no redirect", 32'(redirect_o), 0);

    go_user(6'h3F);

    for (int k = 0; k < 6; k++) begin
      logic [4:0] c;
      pc_i = 32'h0000_1000 + 32'(k) * 16;
      case (k)
        0: begin resv_i = 1;    c = 10; end
        1: begin syscall_i = 1; c = 8;  end
        2: begin break_i = 1;   c = 9;  end
        3: begin trap_i = 1;    c = 13; end
        4: begin ovf_i = 1;     c = 12; end
        default: begin fpu_err_i = 1; c = 15; end
      endcase
      expect_exc("R5 R6 insn cause", 1, c, k == 0, 0, 0);
      go_user(6'h3F);
    end

    pc_i = 32'h0000_2000; priv_i = 1;
    expect_exc("R4 priv user", 1, 10, 1, 0, 0);
    pc_i = 32'h0000_2004; priv_i = 1;
    expect_exc("R4 priv kernel", 0, 0, 0, 0, 0);
    go_user(6'h3F);

    for (int f = 0; f < 2; f++) begin
      pc_i = 32'h0000_3000 + 32'(f) * 8; bus_err_i = 1; bus_fetch_i = f[0];
      expect_exc("R5 bus", 1, f ? 5'd6 : 5'd7, 1, 0, 0);
      go_user(6'h3F);
    end

    for (int i = 0; i < 8; i++) begin
      for (int st = 0; st < 2; st++) begin
        logic [31:0] a;
        a = {i[2:0], 29'h0} + (i[0] ? 32'h1FFF_FFFF : 32'h0);
        pc_i = 32'h0000_4000; mem_valid_i = 1; mem_store_i = st[0]; mem_addr_i = a;
        expect_exc("R3 R7 data space", a[31], st ? 5'd5 : 5'd4, 1, 1, a);
        if (a[31]) go_user(6'h3F);
      end
    end

    pc_i = 32'h8000_0040;
    expect_exc("R3 fetch space", 1, 4, 1, 1, 32'h8000_0040);
    pc_i = 32'h8000_0044; mem_valid_i = 1; mem_addr_i = 32'hF000_0000;
    expect_exc("R3 kernel access", 0, 0, 0, 0, 0);
    go_user(6'h3F);

    for (int s = 1; s < 64; s++) begin
      logic [5:0] v;
      v = 6'(s);
      pc_i = 32'h0000_5000 + 32'(s) * 4;
      bus_err_i = v[0]; mem_valid_i = v[1]; mem_addr_i = 32'h9000_0000;
      resv_i = v[2]; syscall_i = v[3]; break_i = v[4]; ovf_i = v[5];
      irq_i = 6'h01; boundary_i = 1;
      expect_exc("R8 R10 priority", 1, prio_code(v), v[2:0] != 0, v[1:0] == 2'b10, 32'h9000_0000);
      go_user(6'h3F);
    end

    pc_i = 32'h0000_6000; nmi_i = 1; resv_i = 1;
    expect_exc("R9 nmi edge", 1, 0, 0, 0, 0);
    go_user(6'h3F);
    pc_i = 32'h0000_6010;
    expect_exc("R9 nmi held", 0, 0, 0, 0, 0);
    nmi_i = 0;
    @(negedge clk);

    go_user(6'b010101);
    for (int i = 0; i < 6; i++) begin
      for (int b = 0; b < 2; b++) begin
        bit t;
        t = b[0] & m_mask[i];
        pc_i = 32'h0000_7000 + 32'(i) * 16 + 32'(b) * 4;
        irq_i = 6'(1 << i); boundary_i = b[0];
        expect_exc("R10 irq", t, 0, 0, 0, 0);
        if (t) go_user(6'b010101);
      end
    end

    pc_i = 32'h0000_8000; syscall_i = 1;
    expect_exc("R11 setup", 1, 8, 0, 0, 0);
    eret_i = 1;
    #1;
    chk(redirect_o === 1'b1 && redirect_pc_o === 32'h0000_8004, "R11 eret target", redirect_pc_o, 32'h0000_8004);
    @(negedge clk);
    m_mode = m_prev;
    idle();
    chk(kernel_o === 1'b0, "R11 mode restore", 32'(kernel_o), 0);

    pc_i = 32'h0000_8100; syscall_i = 1; eret_i = 1;
    expect_exc("R11 exc wins", 1, 8, 0, 0, 0);
    go_user(6'b010101);

    st_we_i = 1; st_mode_i = 1; st_mask_i = 6'h00;
    @(negedge clk);
    idle();
    state_chk("R12 user write ignored");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule